// File: doc/BRIEF.md
# Prioritized Mirrored Address Decoder

This block decodes CPU bus accesses against a fixed table of address ranges. The table is set by parameters. Each entry has an inclusive first and last address, a mirror mask, an optional explicit offset mask and an access kind. Address bits set in an entry's mirror mask take no part in the match, so one range answers at every mirrored copy. The block applies a global address mask to every incoming address before any range compare.

For each valid access the block produces a one-hot region select and an offset relative to the start of the chosen range. Reads and writes are matched separately, so a read-only entry can sit in front of a lower-priority entry that takes the writes to the same addresses. When entries overlap, the lowest table index wins. Accesses that no entry claims raise an unmapped flag and an error strobe. Entries of the no-operation kind also report unmapped, but they keep the error strobe low. An unmapped read drives a fill value, and a parameter chooses whether that value is all zeros or all ones.

Top module: `mirrored_addr_decoder`

## Requirements
- R1: An entry matches when the globally masked address, with the entry's mirror bits cleared, is at least the entry's first address and at most its last address (mirror bits cleared too). Both bounds are inclusive.
- R2: Setting bits in an entry's mirror mask makes the range respond at every combination of those bits. With mirror 0xA000, a range at 0x4FF0 also answers at 0x6FF0, 0xCFF0 and 0xEFF0.
- R3: The offset is (address − first address) AND offset mask. The offset mask is the bitwise NOT of the mirror unless an explicit mask is configured. A read at 0xCFF7 to the range above gives offset 0x0007.
- R4: When several entries match, only the lowest-index one is selected. The select output is one-hot or zero.
- R5: The global mask is ANDed onto the address before any comparison or offset computation.
- R6: A read-only entry (kind code 1) does not decode writes. Such writes go to the next matching entry, or they are unmapped.
- R7: A write-only entry (kind code 2) does not decode reads. Kind code 0 decodes both reads and writes.
- R8: An access claimed by no entry gives select 0, offset 0, unmapped 1 and error 1.
- R9: An access claimed by a no-operation entry (kind code 3) gives select 0, offset 0, unmapped 1 and error 0.
- R10: On an unmapped read the fill output is all ones when FILL_ONES is 1 and all zeros otherwise. In every other case the fill output is 0.
- R11: Results appear on the outputs one clock after the accepting edge of `acc_valid`. out_valid mirrors `acc_valid` delayed by one clock. All other outputs hold while `acc_valid` is low.
- R12: While reset is active, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W | Access address |
| out_valid | output | 1 | Results below belong to the access of the previous cycle |
| out_sel | output | N | One-hot region select |
| out_offset | output | ADDR_W | Region-relative offset |
| out_unmapped | output | 1 | Access not decoded, or decoded as no-operation |
| out_err | output | 1 | Unmapped access strobe |
| out_fill | output | DATA_W | Fill data for unmapped reads |

## Verification
Every result (select, offset, unmapped, error, fill and out_valid) is due exactly one clock after the edge that accepts an access. The bench drives each access on a falling edge, lets one rising edge pass, and samples 2 ns later. This means each access is checked in the single cycle that it owns. The sweep covers every 16-bit address as both a read and a write on two instances that share the same table, one with a narrowing global mask and all-ones fill. A final idle stretch changes the address and the kind while `acc_valid` is low and expects the outputs to hold.

// File: rtl/mad_pkg.sv
package mad_pkg;
  // access kind codes held per table entry
  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,
    ACC_RO  = 2'd1,
    ACC_WO  = 2'd2,
    ACC_NOP = 2'd3
  } acc_kind_e;
endpackage

// File: rtl/mad_range_match.sv
module mad_range_match
  import mad_pkg::*;
#(
  parameter int unsigned       ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE      = '0,
  parameter logic [ADDR_W-1:0] LAST      = '0,
  parameter logic [ADDR_W-1:0] MIRROR    = '0,
  parameter logic [ADDR_W-1:0] OMASK     = '0,
  parameter bit                OMASK_SET = 1'b0,
  parameter logic [1:0]        KIND      = 2'd0
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [ADDR_W-1:0] offset
);
  localparam logic [ADDR_W-1:0] KEEP     = ~MIRROR;
  localparam logic [ADDR_W-1:0] LO       = BASE & KEEP;
  localparam logic [ADDR_W-1:0] HI       = LAST & KEEP;
  localparam logic [ADDR_W-1:0] OFF_MASK = OMASK_SET ? OMASK : KEEP;
  localparam bit                RD_OK    = (KIND != ACC_WO);
  localparam bit                WR_OK    = (KIND != ACC_RO);

  logic [ADDR_W-1:0] folded;
  logic              in_range;

  always_comb begin
    folded   = addr & KEEP;
    in_range = (folded >= LO) && (folded <= HI);
    rd_hit   = in_range && RD_OK;
    wr_hit   = in_range && WR_OK;
    offset   = (addr - BASE) & OFF_MASK;
  end
endmodule

// File: rtl/mad_prio_pick.sv
module mad_prio_pick #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  logic blocked;

  // lowest index wins
  always_comb begin
    blocked = 1'b0;
    grant   = '0;
    for (int i = 0; i < N; i++) begin
      grant[i] = req[i] & ~blocked;
      blocked  = blocked | req[i];
    end
  end
endmodule

// File: rtl/mirrored_addr_decoder.sv
module mirrored_addr_decoder
  import mad_pkg::*;
#(
  parameter int unsigned         ADDR_W      = 16,
  parameter int unsigned         DATA_W      = 8,
  parameter int unsigned         N           = 4,
  parameter logic [ADDR_W-1:0]   GMASK       = 16'hFFFF,
  parameter bit                  FILL_ONES   = 1'b0,
  parameter logic [N*ADDR_W-1:0] RANGE_BASE  = {16'h1000, 16'h8000, 16'h4000, 16'h4FF0},
  parameter logic [N*ADDR_W-1:0] RANGE_LAST  = {16'h1FFF, 16'h80FF, 16'h4FFF, 16'h4FFF},
  parameter logic [N*ADDR_W-1:0] RANGE_MIRR  = {16'h0000, 16'h0000, 16'h0000, 16'hA000},
  parameter logic [N*ADDR_W-1:0] RANGE_OMASK = {16'h000F, 16'h0000, 16'h0000, 16'h0000},
  parameter logic [N-1:0]        RANGE_OSET  = 4'b1000,
  parameter logic [N*2-1:0]      RANGE_KIND  = {2'd2, 2'd3, 2'd0, 2'd1}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic              out_valid,
  output logic [N-1:0]      out_sel,
  output logic [ADDR_W-1:0] out_offset,
  output logic              out_unmapped,
  output logic              out_err,
  output logic [DATA_W-1:0] out_fill
);
  localparam logic [DATA_W-1:0] FILL_VAL = FILL_ONES ? {DATA_W{1'b1}} : {DATA_W{1'b0}};

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0] addr_g;
  logic [N-1:0]      rd_hit, wr_hit, req, grant, nop_mask;
  logic [ADDR_W-1:0] off_arr [N];

  assign addr_g = acc_addr & GMASK;

  for (genvar i = 0; i < N; i++) begin : g_entry
    mad_range_match #(
      .ADDR_W   (ADDR_W),
      .BASE     (RANGE_BASE [i*ADDR_W +: ADDR_W]),
      .LAST     (RANGE_LAST [i*ADDR_W +: ADDR_W]),
      .MIRROR   (RANGE_MIRR [i*ADDR_W +: ADDR_W]),
      .OMASK    (RANGE_OMASK[i*ADDR_W +: ADDR_W]),
      .OMASK_SET(RANGE_OSET[i]),
      .KIND     (RANGE_KIND[i*2 +: 2])
    ) u_match (
      .addr  (addr_g),
      .rd_hit(rd_hit[i]),
      .wr_hit(wr_hit[i]),
      .offset(off_arr[i])
    );
    assign nop_mask[i] = (RANGE_KIND[i*2 +: 2] == ACC_NOP);
  end

  assign req = acc_write ? wr_hit : rd_hit;

  mad_prio_pick #(.N(N)) u_pick (
    .req  (req),
    .grant(grant)
  );

  // next state
  logic [N-1:0]      sel_d;
  logic [ADDR_W-1:0] off_d;
  logic              unm_d, err_d;
  logic [DATA_W-1:0] fill_d;

  always_comb begin
    sel_d = grant & ~nop_mask;
    off_d = '0;
    for (int i = 0; i < N; i++) begin
      if (sel_d[i]) off_d = off_d | off_arr[i];
    end
    err_d  = ~|grant;
    unm_d  = err_d | (|(grant & nop_mask));
    fill_d = (unm_d && !acc_write) ? FILL_VAL : '0;
  end

  // registers, enabled by acc_valid
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      out_valid    <= 1'b0;
      out_sel      <= '0;
      out_offset   <= '0;
      out_unmapped <= 1'b0;
      out_err      <= 1'b0;
      out_fill     <= '0;
    end else begin
      out_valid <= acc_valid;
      if (acc_valid) begin
        out_sel      <= sel_d;
        out_offset   <= off_d;
        out_unmapped <= unm_d;
        out_err      <= err_d;
        out_fill     <= fill_d;
      end
    end
  end

  // R4: never more than one region selected
  a_r4_sel_onehot: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(out_sel));

  // R8: an error strobe always comes with the unmapped flag
  a_r8_err_unmapped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    out_err |-> out_unmapped);

  // R8: a selected region is never reported unmapped
  a_r8_sel_not_unmapped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_sel != '0) |-> !out_unmapped);

  // R10: fill data only on unmapped results
  a_r10_fill_unmapped: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (out_fill != '0) |-> out_unmapped);

  // R11: a valid access yields out_valid one clock later
  a_r11_valid_next: assert property (@(posedge clk) disable iff (!rst_sync_n)
    acc_valid |=> out_valid);

  // R11: results hold when no access is presented
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !acc_valid |=> ($stable(out_sel) && $stable(out_offset) && $stable(out_unmapped)));
endmodule

// File: tb/sim_mirrored_addr_decoder.sv
`timescale 1ns/1ps
module sim_mirrored_addr_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_valid = 1'b0;
  logic acc_write = 1'b0;
  logic [15:0] acc_addr = '0;

  logic        v0, v1, u0_unm, u1_unm, u0_err, u1_err;
  logic [3:0]  s0, s1;
  logic [15:0] o0, o1;
  logic [7:0]  f0, f1;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  mirrored_addr_decoder u0 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .out_valid(v0), .out_sel(s0), .out_offset(o0),
    .out_unmapped(u0_unm), .out_err(u0_err), .out_fill(f0));

  mirrored_addr_decoder #(.GMASK(16'h7FFF), .FILL_ONES(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .out_valid(v1), .out_sel(s1), .out_offset(o1),
    .out_unmapped(u1_unm), .out_err(u1_err), .out_fill(f1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // expected decode of the default table, from the requirements
  task automatic model(input logic [15:0] a_in, input bit wr, input logic [15:0] gm,
                       output logic [3:0] s, output logic [15:0] o,
                       output bit u, output bit e);
    logic [15:0] a, f;
    a = a_in & gm;
    f = a & 16'h5FFF;
    s = '0; o = '0; u = 1'b0; e = 1'b0;
    if (!wr && f >= 16'h4FF0 && f <= 16'h4FFF) begin
      s = 4'b0001; o = (a - 16'h4FF0) & 16'h5FFF;
    end else if (a >= 16'h4000 && a <= 16'h4FFF) begin
      s = 4'b0010; o = a - 16'h4000;
    end else if (a >= 16'h8000 && a <= 16'h80FF) begin
      u = 1'b1;
    end else if (wr && a >= 16'h1000 && a <= 16'h1FFF) begin
      s = 4'b1000; o = (a - 16'h1000) & 16'h000F;
    end else begin
      u = 1'b1; e = 1'b1;
    end
  endtask

  task automatic access(input logic [15:0] a, input bit wr, input string tag);
    logic [3:0] es; logic [15:0] eo; bit eu, ee;
    @(negedge clk);
    acc_valid = 1'b1; acc_write = wr; acc_addr = a;
    @(posedge clk);
    #2;
    model(a, wr, 16'hFFFF, es, eo, eu, ee);
    chk({tag, " u0 sel/off"}, {12'h0, s0, o0}, {12'h0, es, eo});
    chk({tag, " u0 unm/err R8 R9"}, {u0_unm, u0_err}, {eu, ee});
    chk({tag, " u0 fill R10"}, f0, 8'h00);
    model(a, wr, 16'h7FFF, es, eo, eu, ee);
    chk({tag, " u1 R5 sel/off"}, {12'h0, s1, o1}, {12'h0, es, eo});
    chk({tag, " u1 R5 unm/err"}, {u1_unm, u1_err}, {eu, ee});
    chk({tag, " u1 fill R10"}, f1, (eu && !wr) ? 8'hFF : 8'h00);
    chk({tag, " valid R11"}, {v0, v1}, 2'b11);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R12: reset state
    chk("R12 reset u0", {v0, s0, o0, u0_unm, u0_err, f0}, '0);
    chk("R12 reset u1", {v1, s1, o1, u1_unm, u1_err, f1}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // directed cases
    access(16'h4FF0, 1'b0, "R2 base");
    access(16'h6FF0, 1'b0, "R2 mirror");
    access(16'hCFF0, 1'b0, "R2 mirror");
    access(16'hEFF0, 1'b0, "R2 mirror");
    access(16'hCFF7, 1'b0, "R3 default mask");
    chk("R3 offset 0007", {16'h0, o0}, 32'h0007);
    access(16'h1015, 1'b1, "R3 explicit mask");
    chk("R3 explicit offset", {16'h0, o0}, 32'h0005);
    access(16'h4FF5, 1'b0, "R4 overlap");
    chk("R4 entry0 wins", {28'h0, s0}, 32'h1);
    access(16'h4FF5, 1'b1, "R6 write falls through");
    chk("R6 entry1 takes write", {28'h0, s0}, 32'h2);
    access(16'h6FF0, 1'b1, "R6 write unmapped");
    access(16'h1005, 1'b0, "R7 read of write-only");
    access(16'h4000, 1'b0, "R1 low bound");
    access(16'h4FFF, 1'b1, "R1 high bound");
    access(16'h3FFF, 1'b0, "R1 below");
    access(16'h8000, 1'b0, "R9 nop read");
    access(16'h80FF, 1'b1, "R9 nop write");
    access(16'h8100, 1'b0, "R8 past nop");
    access(16'h0000, 1'b0, "R10 unmapped read");
    access(16'h0000, 1'b1, "R10 unmapped write");
    access(16'hC010, 1'b0, "R5 global mask");

    // exhaustive sweep
    for (int a = 0; a < 65536; a++) begin
      for (int w = 0; w < 2; w++) begin
        access(a[15:0], w[0], "R1 sweep");
      end
    end

    // R11: hold while idle
    access(16'h4FF5, 1'b0, "R11 prime");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b1; acc_addr = 16'h8000 + k[15:0];
      @(posedge clk);
      #2;
      chk("R11 hold sel/off", {12'h0, s0, o0}, {12'h0, 4'b0001, 16'h0005});
      chk("R11 hold flags", {v0, u0_unm, u0_err, f1}, {3'b000, 8'h00});
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (180000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog R11 act=timeout exp=done");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule